// File: doc/BRIEF.md
# I2C Ten-Bit Address Slave Receiver

This block is a write-only I2C slave that answers to a 10-bit address. It samples the serial clock and data lines through synchronisers, detects START and STOP conditions, and assembles each incoming byte in a shift register. The master first sends a header byte that carries the two upper address bits. It then sends a byte with the eight lower address bits. Data bytes follow.

A single 8-bit compare register, loaded by the host, is used for both address halves. After each address byte is acknowledged, the block raises an address-update flag. It then holds the clock line low until the host has written the compare register: the low address half after the header byte, and the header pattern again after the low byte. Data bytes are never clock-stretched.

Each acknowledged byte, address bytes included, is copied into a receive buffer, and a buffer-full flag is set. A byte that completes while the buffer is still full is refused: it is not acknowledged and it raises an overflow flag. Both bus lines are open-drain and are modelled as pull-low enables.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset, `sda_oe`, `scl_oe`, `rx_full`, `irq_flag`, `ovf_flag` and `addr_upd` are all 0. The compare register holds `CMP_INIT`, which is 8'hF0 by default, so a header byte of 8'hF0 is accepted before the host writes anything.
- R2: The header byte is accepted only if bits [7:3] are 5'b11110, bits [2:1] equal compare-register bits [2:1], and bit 0 (the read/write bit) is 0. An accepted header is acknowledged by pulling SDA low during the 9th clock. Any other header is not acknowledged, and the slave ignores the bus until the next START.
- R3: At the 9th rising SCL edge of an acknowledged header byte, `addr_upd` is set. From the following falling edge, `scl_oe` holds SCL low for as long as `addr_upd` stays set. A host write (`cmp_we`) loads the compare register, clears `addr_upd` and releases SCL.
- R4: The second address byte is compared with all 8 bits of the compare register. On a match it is acknowledged, `addr_upd` is set again and SCL is held as in R3. On a mismatch it is not acknowledged, and the slave waits for a START.
- R5: Every acknowledged byte, whether address or data, is copied to `rx_data` and sets `rx_full` after its 8th bit. A one-cycle `rx_rd` pulse clears `rx_full`.
- R6: `irq_flag` is set at the 9th rising SCL edge of every acknowledged byte. It stays set until the host pulses `irq_clr`.
- R7: If a data byte completes while `rx_full` is set, `ovf_flag` is set, the byte is not acknowledged, `rx_data` keeps its old value and `irq_flag` is not set. `ovf_flag` stays set through buffer reads until `ovf_clr` is pulsed.
- R8: `scl_oe` stays 0 during and after data bytes.
- R9: A STOP returns the slave to idle, and bytes clocked afterwards without a START are not acknowledged. Any START, including a repeated START in the middle of data, restarts header decoding.
- R10: `sda_oe` changes only while the SCL line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| cmp_we | input | 1 | Host write strobe for the compare register |
| cmp_wdata | input | 8 | Value written to the compare register |
| rx_rd | input | 1 | Host read of the receive buffer, clears `rx_full` |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| irq_flag | output | 1 | Byte-acknowledged interrupt flag |
| irq_clr | input | 1 | Clears `irq_flag` |
| ovf_flag | output | 1 | Receive overflow flag |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| addr_upd | output | 1 | Host must reload the compare register |

## Verification
The bench covers four groups of corner cases.

- **Stretch handshake.** The bench checks that SCL stays held through a long host delay and is released only by the compare write. A design that released SCL early would let the master clock the low address byte against the stale header value.
- **Overflow.** The bench refuses a byte by leaving the buffer unread. A design that got this wrong would acknowledge the byte, overwrite the held data or raise the interrupt.
- **Address rejection.** The bench sends header mismatches on the upper bits and on the read/write bit, a low-byte mismatch, and traffic after a STOP with no START. Each would expose a slave that acknowledges foreign addresses or stays attached to the bus.
- **Repeated START.** The bench sends a repeated START in the middle of the data phase. A design that kept its old state would treat the new header as data instead of re-decoding it.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int          BYTE_W = 8;
  localparam logic [4:0]  HDR10  = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYTE,
    ST_ACK_WAIT,
    ST_ACK_HI,
    ST_ACK_END,
    ST_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    K_HI,
    K_LO,
    K_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
  parameter int                 WIDTH   = 2,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c10_bus_events.sv
module i2c10_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA moving while SCL is high on both samples marks a bus condition
  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c10_shift.sv
module i2c10_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic         last,
  output logic [W-1:0] word
);
  localparam int CNT_W = $clog2(W);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W-1:0]     sh_q;

  assign last = en && (cnt_q == CNT_W'(W - 1));
  assign word = {sh_q[W-2:0], bit_i};

  always_comb begin
    cnt_n = cnt_q;
    if (clr)       cnt_n = '0;
    else if (last) cnt_n = '0;
    else if (en)   cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh_q <= '0;
    else if (en) sh_q <= word;
  end
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
  import i2c10_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CMP_INIT    = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       cmp_we,
  input  logic [7:0] cmp_wdata,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       irq_flag,
  input  logic       irq_clr,
  output logic       ovf_flag,
  input  logic       ovf_clr,
  output logic       addr_upd
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // line sampling and bus events
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c10_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  i2c10_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic              sh_clr, sh_en, sh_last;
  logic [BYTE_W-1:0] byte_w;

  i2c10_shift #(.W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (sh_clr),
    .en    (sh_en),
    .bit_i (sda_s),
    .last  (sh_last),
    .word  (byte_w)
  );

  // control state
  rx_state_e   st_q, st_n;
  byte_kind_e  kind_q, kind_n;
  logic        ack_q, ack_n;
  logic        full_q, full_n;
  logic        ua_q, ua_n;
  logic        irq_q, irq_n;
  logic        ovf_q, ovf_n;
  logic        sda_oe_q, sda_oe_n;
  logic        ld_rx;
  logic [7:0]  cmp_q, rxd_q;
  logic        hi_match, lo_match, buf_busy;

  assign hi_match = (byte_w[7:3] == HDR10) && (byte_w[2:1] == cmp_q[2:1]) && !byte_w[0];
  assign lo_match = (byte_w == cmp_q);
  assign buf_busy = full_q && !rx_rd;

  always_comb begin
    st_n     = st_q;
    kind_n   = kind_q;
    ack_n    = ack_q;
    full_n   = full_q;
    ua_n     = ua_q;
    irq_n    = irq_q;
    ovf_n    = ovf_q;
    sda_oe_n = sda_oe_q;
    ld_rx    = 1'b0;
    sh_clr   = 1'b0;
    sh_en    = 1'b0;

    if (rx_rd)   full_n = 1'b0;
    if (irq_clr) irq_n  = 1'b0;
    if (ovf_clr) ovf_n  = 1'b0;
    if (cmp_we)  ua_n   = 1'b0;

    if (stop_det) begin
      st_n     = ST_IDLE;
      sda_oe_n = 1'b0;
      sh_clr   = 1'b1;
    end else if (start_det) begin
      st_n     = ST_BYTE;
      kind_n   = K_HI;
      sda_oe_n = 1'b0;
      sh_clr   = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_BYTE: begin
          if (scl_rise) begin
            sh_en = 1'b1;
            if (sh_last) begin
              unique case (kind_q)
                K_HI: begin
                  if (hi_match) begin
                    ack_n = 1'b1; ld_rx = 1'b1; full_n = 1'b1; st_n = ST_ACK_WAIT;
                  end else begin
                    st_n = ST_IDLE;
                  end
                end
                K_LO: begin
                  if (lo_match) begin
                    ack_n = 1'b1; ld_rx = 1'b1; full_n = 1'b1; st_n = ST_ACK_WAIT;
                  end else begin
                    st_n = ST_IDLE;
                  end
                end
                default: begin
                  st_n = ST_ACK_WAIT;
                  if (buf_busy) begin
                    ack_n = 1'b0; ovf_n = 1'b1;
                  end else begin
                    ack_n = 1'b1; ld_rx = 1'b1; full_n = 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall) begin
            sda_oe_n = ack_q;
            st_n     = ST_ACK_HI;
          end
        end
        ST_ACK_HI: begin
          if (scl_rise) begin
            if (ack_q) begin
              irq_n = 1'b1;
              if (kind_q != K_DATA) ua_n = 1'b1;
            end
            st_n = ST_ACK_END;
          end
        end
        ST_ACK_END: begin
          if (scl_fall) begin
            sda_oe_n = 1'b0;
            unique case (kind_q)
              K_HI:    begin kind_n = K_LO;   st_n = ST_HOLD; end
              K_LO:    begin kind_n = K_DATA; st_n = ST_HOLD; end
              default: st_n = ST_BYTE;
            endcase
          end
        end
        ST_HOLD: begin
          if (!ua_q) st_n = ST_BYTE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= K_HI;
      ack_q    <= 1'b0;
      full_q   <= 1'b0;
      ua_q     <= 1'b0;
      irq_q    <= 1'b0;
      ovf_q    <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      kind_q   <= kind_n;
      ack_q    <= ack_n;
      full_q   <= full_n;
      ua_q     <= ua_n;
      irq_q    <= irq_n;
      ovf_q    <= ovf_n;
      sda_oe_q <= sda_oe_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cmp_q <= CMP_INIT;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rxd_q <= '0;
    else if (ld_rx) rxd_q <= byte_w;
  end

  assign sda_oe   = sda_oe_q;
  assign scl_oe   = (st_q == ST_HOLD) && ua_q;
  assign rx_data  = rxd_q;
  assign rx_full  = full_q;
  assign irq_flag = irq_q;
  assign ovf_flag = ovf_q;
  assign addr_upd = ua_q;
endmodule

// File: rtl/i2c10_rx_chk.sv
module i2c10_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       addr_upd,
  input logic       cmp_we,
  input logic       rx_full,
  input logic [7:0] rx_data,
  input logic       ovf_flag,
  input logic       irq_flag
);
  // R10: acknowledge drive only moves while the clock line is low
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R3: stretching starts with the line already low
  a_r3_stretch_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_i);

  // R3: the hold persists until the host writes the compare register
  a_r3_hold_until_write: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !cmp_we) |=> scl_oe);

  // R3: only a compare write clears the update flag
  a_r3_ua_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_upd) |-> $past(cmp_we));

  // R6: an update request always comes with the interrupt flag
  a_r6_ua_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_upd) |-> irq_flag);

  // R7: overflow only when the buffer was occupied
  a_r7_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(rx_full));

  // R7: an overflowing byte leaves the buffer as it was
  a_r7_ovf_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $stable(rx_data));
endmodule

bind i2c10_slave_rx i2c10_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .scl_oe   (scl_oe),
  .addr_upd (addr_upd),
  .cmp_we   (cmp_we),
  .rx_full  (rx_full),
  .rx_data  (rx_data),
  .ovf_flag (ovf_flag),
  .irq_flag (irq_flag)
);

// File: tb/tb_i2c10_slave_rx.sv
module tb_i2c10_slave_rx;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       cmp_we = 1'b0, rx_rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] cmp_wdata = 8'h00;
  logic       scl_oe, sda_oe, rx_full, irq_flag, ovf_flag, addr_upd;
  logic [7:0] rx_data;
  logic       scl_line, sda_line;

  logic [7:0] exp_q[$];
  int         n_chk = 0, n_bad = 0, r10_viol = 0;
  bit         done = 1'b0;
  logic       bf_prev = 1'b0, sda_prev = 1'b0;
  logic       ack;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c10_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .irq_flag(irq_flag),
    .irq_clr(irq_clr), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .addr_upd(addr_upd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every buffer load is compared with the next expected byte (R5)
  always @(negedge clk) begin
    logic [7:0] e;
    bf_prev  <= rx_full;
    sda_prev <= sda_oe;
    if (rst_n && rx_full && !bf_prev) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 actual=%0h expected=none", rx_data);
      end else begin
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          n_bad++;
          $display("FAIL R5 actual=%0h expected=%0h", rx_data, e);
        end
      end
    end
    if (rst_n && (sda_oe !== sda_prev) && scl_line) r10_viol++;
  end

  task automatic host_cmp(input logic [7:0] v);
    cmp_wdata = v; cmp_we = 1'b1; tick(1); cmp_we = 1'b0;
  endtask
  task automatic host_rd();
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
  endtask
  task automatic host_irq_clr();
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
  endtask
  task automatic host_ovf_clr();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
  endtask

  task automatic wait_scl_high();
    while (!scl_line) tick(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; wait_scl_high(); tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; wait_scl_high(); tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; wait_scl_high(); tick(H);
      scl_m = 1'b0; tick(H);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; wait_scl_high(); tick(H / 2);
    acked = !sda_line;
    tick(H / 2);
    scl_m = 1'b0; tick(H);
  endtask

  // driver: queue the byte when it should land in the buffer, then clock it out
  task automatic xfer(input logic [7:0] b, input bit exp_ack, input string req);
    logic a;
    if (exp_ack) exp_q.push_back(b);
    send_byte(b, a);
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  // full address phase for 10'h2B5 with a clean handshake
  task automatic addr_phase();
    xfer(8'hF4, 1'b1, "R2 header ack");
    host_rd(); host_irq_clr(); host_cmp(8'hB5);
    xfer(8'hB5, 1'b1, "R4 low ack");
    host_rd(); host_irq_clr(); host_cmp(8'hF4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(!sda_oe && !scl_oe, "R1 line drives", int'({sda_oe, scl_oe}), 0);
    chk(!rx_full && !irq_flag && !ovf_flag && !addr_upd, "R1 flags",
        int'({rx_full, irq_flag, ovf_flag, addr_upd}), 0);

    // R1 reset compare value accepts header 8'hF0
    bus_start();
    xfer(8'hF0, 1'b1, "R1 reset compare");
    tick(6);
    chk(scl_oe == 1'b1, "R3 hold after header", int'(scl_oe), 1);
    host_rd(); host_irq_clr();
    host_cmp(8'hF4);
    bus_stop();

    // main transfer
    bus_start();
    xfer(8'hF4, 1'b1, "R2 header ack");
    chk(irq_flag == 1'b1, "R6 irq on header", int'(irq_flag), 1);
    chk(addr_upd == 1'b1, "R3 update flag", int'(addr_upd), 1);
    tick(6);
    chk(scl_oe && !scl_line, "R3 scl held", int'({scl_oe, scl_line}), 2);
    host_rd(); host_irq_clr();
    chk(irq_flag == 1'b0, "R6 irq clear", int'(irq_flag), 0);
    tick(60);
    chk(scl_oe == 1'b1, "R3 still held", int'(scl_oe), 1);
    host_cmp(8'hB5);
    chk(addr_upd == 1'b0, "R3 write clears flag", int'(addr_upd), 0);
    tick(3);
    chk(scl_oe == 1'b0, "R3 released", int'(scl_oe), 0);
    xfer(8'hB5, 1'b1, "R4 low ack");
    chk(addr_upd == 1'b1, "R4 update again", int'(addr_upd), 1);
    tick(6);
    chk(scl_oe == 1'b1, "R4 hold after low", int'(scl_oe), 1);
    host_rd(); host_irq_clr(); host_cmp(8'hF4);
    xfer(8'h3C, 1'b1, "R5 data ack");
    chk(irq_flag == 1'b1, "R6 irq on data", int'(irq_flag), 1);
    tick(6);
    chk(scl_oe == 1'b0, "R8 no data stretch", int'(scl_oe), 0);
    chk(rx_full == 1'b1, "R5 full set", int'(rx_full), 1);
    host_rd(); host_irq_clr();
    chk(rx_full == 1'b0, "R5 read clears", int'(rx_full), 0);
    xfer(8'hA5, 1'b1, "R5 second data");
    host_irq_clr();
    xfer(8'h5A, 1'b0, "R7 overflow nack");
    chk(ovf_flag == 1'b1, "R7 overflow flag", int'(ovf_flag), 1);
    chk(rx_data == 8'hA5, "R7 buffer kept", int'(rx_data), 8'hA5);
    chk(irq_flag == 1'b0, "R7 no irq", int'(irq_flag), 0);
    chk(scl_oe == 1'b0, "R8 no stretch on overflow", int'(scl_oe), 0);
    host_rd();
    chk(ovf_flag == 1'b1, "R7 ovf sticky", int'(ovf_flag), 1);
    host_ovf_clr();
    chk(ovf_flag == 1'b0, "R7 ovf clear", int'(ovf_flag), 0);
    bus_stop();

    // R9 bytes after STOP without START
    xfer(8'hF4, 1'b0, "R9 idle after stop");
    chk(rx_full == 1'b0 && addr_upd == 1'b0, "R9 no load", int'({rx_full, addr_upd}), 0);

    // R2 header mismatch on A9:A8, then trailing byte ignored
    bus_start();
    xfer(8'hF6, 1'b0, "R2 header mismatch");
    xfer(8'hB5, 1'b0, "R2 ignored until start");
    chk(addr_upd == 1'b0 && rx_full == 1'b0, "R2 no side effect", int'({addr_upd, rx_full}), 0);
    bus_stop();

    // R2 read bit set
    bus_start();
    xfer(8'hF5, 1'b0, "R2 read bit");
    bus_stop();

    // R4 low byte mismatch
    bus_start();
    xfer(8'hF4, 1'b1, "R2 header ack");
    host_rd(); host_irq_clr(); host_cmp(8'hB5);
    xfer(8'hB6, 1'b0, "R4 low mismatch");
    chk(addr_upd == 1'b0 && irq_flag == 1'b0, "R4 no update", int'({addr_upd, irq_flag}), 0);
    xfer(8'h77, 1'b0, "R4 idle after mismatch");
    bus_stop();
    host_cmp(8'hF4);

    // R9 repeated START in data phase
    bus_start();
    addr_phase();
    xfer(8'h11, 1'b1, "R9 data before restart");
    host_rd(); host_irq_clr();
    bus_start();
    addr_phase();
    xfer(8'h22, 1'b1, "R9 data after restart");
    host_rd(); host_irq_clr();
    bus_stop();

    tick(10);
    chk(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);
    chk(r10_viol == 0, "R10 sda moves only with scl low", r10_viol, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule